// File: doc/BRIEF.md
# Timed Strobe Controller for an Asynchronous Byte-Lane Non-Volatile RAM

This block sits between an on-chip requester and an external asynchronous parallel non-volatile RAM of 262,144 sixteen-bit words. It takes one word operation at a time over a ready/valid handshake. Each request carries a read or write flag, an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns the request into active-low strobes for chip select, write, output drive and the two byte lanes. It also presents the address and steers the direction of the data bus. The bus comes out as separate out, in and drive-enable signals, so the pad ring can build the tristate.

Every interval is a whole number of system clock cycles. Each one is the ceiling of a picosecond figure divided by the clock period, and is never less than one cycle. Write cycles are timed by the write strobe. Each lane is written only when its mask bit is set. After reset the controller holds the memory idle for a startup window in which chip select and write stay high and no request is taken. That window gives the supply recovery time the memory needs after power-up or a brownout.

Top module: `parram_ctrl`

## Requirements
- R1: After reset is released, `memCeN` and `memWeN` stay high, `memDqOe` stays low and `reqReady` stays low for STARTUP_CYCLES cycles. While reset is held, all strobes are high and `memDqOe` and `rspValid` are low.
- R2: `reqReady` is high only while the controller is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. A read keeps `reqReady` low for 10 cycles and a write for 9 cycles at the default timing.
- R3: A read holds `memCeN` and `memOeN` low and `memWeN` high for 9 cycles at the default timing. `memAddr` equals the request address throughout. Mask bit 0 drives `memLbN` low (bits 7:0) and mask bit 1 drives `memUbN` low (bits 15:8).
- R4: Read data is sampled from `memDqIn` at the last read cycle and returned on `rspData` with a single-cycle `rspValid` pulse. A lane whose mask bit is clear returns zero.
- R5: A write holds `memCeN` and `memWeN` low and `memOeN` high for 5 cycles at the default timing, with the byte enables set by the mask as in R3. This pulse covers the write-pulse, data-setup and address-to-end-of-write minimums.
- R6: After the write strobe rises, a recovery window of 4 cycles follows at the default timing. In it all strobes are high while `memAddr` and `memDqOut` keep the request values and the bus is still driven. Pulse plus recovery is at least the 35 ns cycle time.
- R7: `memDqOe` is high only during the write pulse and its recovery. It is never high in a cycle where `memOeN` is low, or in the cycle right after one.
- R8: After a read, chip select, output enable and both byte enables stay high, with the bus undriven, for at least one gap cycle before the next access.
- R9: A write with mask 2'b00 asserts neither byte enable and leaves both lanes of the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, which restarts the startup window |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspData | output | 16 | Read data, zero in unselected lanes |
| memAddr | output | 18 | Address to the memory |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqIn | input | 16 | Data returned from the memory |
| memDqOe | output | 1 | Drive enable for the data bus |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memUbN | output | 1 | Upper lane enable, active low |
| memLbN | output | 1 | Lower lane enable, active low |

## Verification
The assertions assume the requester holds a request's fields stable for the cycle in which it is accepted. They also assume the external memory never drives `memDqIn` in a way that feeds back into the strobes, so every strobe property depends only on the controller's own sequencing. The stimulus only changes request fields at the falling edge, drops `reqValid` in the cycle after acceptance and never raises it in the last startup cycle. The bench memory model returns stored data only while chip select and output enable are both low, which matches what the read-capture property expects.

// File: rtl/parram_pkg.sv
package parram_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WREC,
    ST_GAP
  } seqState_t;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic laneEn;
    logic drive;
    logic capture;
    logic load;
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/parram_seq.sv
module parram_seq
  import parram_pkg::*;
#(
  parameter int START_CYC = 1,
  parameter int RD_CYC    = 1,
  parameter int WP_CYC    = 1,
  parameter int REC_CYC   = 1,
  parameter int GAP_CYC   = 1,
  parameter int CNT_W     = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam logic [CNT_W-1:0] START_LD = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD    = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);

  seqState_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic cntDone;

  assign cntDone = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_START;
      cntQ   <= START_LD;
    end else begin
      unique case (stateQ)
        ST_START: begin
          if (cntDone) stateQ <= ST_IDLE;
          else         cntQ   <= cntQ - 1'b1;
        end
        ST_IDLE: begin
          if (reqValid) begin
            if (reqWrite) begin
              stateQ <= ST_WPULSE;
              cntQ   <= WP_LD;
            end else begin
              stateQ <= ST_READ;
              cntQ   <= RD_LD;
            end
          end
        end
        ST_READ: begin
          if (cntDone) begin
            stateQ <= ST_GAP;
            cntQ   <= GAP_LD;
          end else cntQ <= cntQ - 1'b1;
        end
        ST_WPULSE: begin
          if (cntDone) begin
            stateQ <= ST_WREC;
            cntQ   <= REC_LD;
          end else cntQ <= cntQ - 1'b1;
        end
        ST_WREC: begin
          if (cntDone) stateQ <= ST_IDLE;
          else         cntQ   <= cntQ - 1'b1;
        end
        ST_GAP: begin
          if (cntDone) stateQ <= ST_IDLE;
          else         cntQ   <= cntQ - 1'b1;
        end
        default: stateQ <= ST_START;
      endcase
    end
  end

  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    strb = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, laneEn: 1'b0,
             drive: 1'b0, capture: 1'b0, load: 1'b0};
    unique case (stateQ)
      ST_IDLE: strb.load = reqValid;
      ST_READ: begin
        strb.ceN     = 1'b0;
        strb.oeN     = 1'b0;
        strb.laneEn  = 1'b1;
        strb.capture = cntDone;
      end
      ST_WPULSE: begin
        strb.ceN    = 1'b0;
        strb.weN    = 1'b0;
        strb.laneEn = 1'b1;
        strb.drive  = 1'b1;
      end
      ST_WREC: strb.drive = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/parram_dp.sv
module parram_dp
  import parram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  laneEnN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdMasked;
  logic [DATA_W-1:0] rdQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign rdMasked[lane*LANE_W +: LANE_W] =
      maskQ[lane] ? memDqIn[lane*LANE_W +: LANE_W] : '0;
    assign laneEnN[lane] = ~(strb.laneEn & maskQ[lane]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ  <= '0;
      rspQ <= 1'b0;
    end else begin
      rspQ <= strb.capture;
      if (strb.capture) rdQ <= rdMasked;
    end
  end

  assign rspValid = rspQ;
  assign rspData  = rdQ;
  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memDqOe  = strb.drive;
  assign memCeN   = strb.ceN;
  assign memWeN   = strb.weN;
  assign memOeN   = strb.oeN;

endmodule

// File: rtl/parram_ctrl.sv
module parram_ctrl
  import parram_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 16,
  parameter int CLK_PS         = 4000,
  parameter int CYCLE_PS       = 35000,
  parameter int WPULSE_PS      = 15000,
  parameter int ADDR_END_PS    = 18000,
  parameter int DATA_SETUP_PS  = 10000,
  parameter int RECOVER_PS     = 12000,
  parameter int HIGH_PS        = 2000,
  parameter int STARTUP_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN
);

  localparam int START_CYC = atLeastOne(STARTUP_CYCLES);
  localparam int RD_CYC    = atLeastOne(ceilDiv(CYCLE_PS, CLK_PS));
  localparam int WP_CYC    = atLeastOne(ceilDiv(
    maxOf(WPULSE_PS, maxOf(ADDR_END_PS, DATA_SETUP_PS)), CLK_PS));
  localparam int REC_CYC   = atLeastOne(maxOf(ceilDiv(RECOVER_PS, CLK_PS),
                                              RD_CYC - WP_CYC));
  localparam int GAP_CYC   = atLeastOne(ceilDiv(HIGH_PS, CLK_PS));
  localparam int CNT_MAX   = maxOf(maxOf(START_CYC, RD_CYC),
                                   maxOf(maxOf(WP_CYC, REC_CYC), GAP_CYC));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  strobe_t    strb;
  logic [1:0] laneEnN;

  parram_seq #(
    .START_CYC(START_CYC),
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .REC_CYC  (REC_CYC),
    .GAP_CYC  (GAP_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  parram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANE_W(DATA_W / 2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .rspValid(rspValid),
    .rspData (rspData),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqIn (memDqIn),
    .memDqOe (memDqOe),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .laneEnN (laneEnN)
  );

  assign memLbN = laneEnN[0];
  assign memUbN = laneEnN[1];

endmodule

// File: rtl/parram_chk.sv
module parram_chk #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int START_CYC = 1,
  parameter int WP_CYC    = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN
);

  localparam int SW = $clog2(START_CYC + 1);
  localparam int WW = $clog2(WP_CYC + 2);

  logic [SW-1:0] startCnt;
  logic [WW-1:0] weRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt <= '0;
      weRun    <= '0;
    end else begin
      if (startCnt != SW'(START_CYC)) startCnt <= startCnt + 1'b1;
      if (memWeN)                      weRun <= '0;
      else if (weRun != WW'(WP_CYC + 1)) weRun <= weRun + 1'b1;
    end
  end

  p_startup_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startCnt < SW'(START_CYC)) |-> (memCeN && memWeN && !memDqOe && !reqReady));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN || memDqOe) |-> !reqReady);

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memCeN && memWeN));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_write_strobes_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN && memDqOe));

  p_write_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun >= WW'(WP_CYC)));

  p_write_addr_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  p_recovery_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> ($stable(memAddr) && $stable(memDqOut) && memDqOe));

  p_bus_turnaround_r7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && $past(memOeN)));

  p_read_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (memCeN && !memDqOe && !reqReady));

endmodule

bind parram_ctrl parram_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .START_CYC(START_CYC),
  .WP_CYC   (WP_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memAddr (memAddr),
  .memDqOut(memDqOut),
  .memDqOe (memDqOe),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN)
);

// File: tb/parram_ctrl_bench.sv
module parram_ctrl_bench;

  // Default timing at 4 ns: read 9, write pulse 5, recovery 4, gap 1
  localparam int START  = 20;
  localparam int RD_EXP = 9;
  localparam int WP_EXP = 5;
  localparam int RC_EXP = 4;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, reqValid, reqReady, reqWrite, rspValid;
  logic [17:0] reqAddr, memAddr;
  logic [15:0] reqWdata, rspData, memDqOut, memDqIn;
  logic [1:0]  reqMask;
  logic        memDqOe, memCeN, memWeN, memOeN, memUbN, memLbN;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [15:0] bmem   [16];
  logic [15:0] shadow [16];

  parram_ctrl #(.STARTUP_CYCLES(START)) u_parram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqIn(memDqIn),
    .memDqOe(memDqOe), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memUbN(memUbN), .memLbN(memLbN)
  );

  // Memory model: writes during CE/WE overlap, drives data when CE/OE low
  always @(negedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memLbN) bmem[memAddr[3:0]][7:0]  <= memDqOut[7:0];
      if (!memUbN) bmem[memAddr[3:0]][15:8] <= memDqOut[15:8];
    end
  end
  always_comb memDqIn = (!memCeN && !memOeN) ? bmem[memAddr[3:0]] : 16'h0000;

  // {write, addr, data, mask}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 18'h00003, 16'h1234, 2'b11},
    {1'b0, 18'h00003, 16'h0000, 2'b11},
    {1'b1, 18'h3FFF3, 16'hABCD, 2'b01},
    {1'b0, 18'h00003, 16'h0000, 2'b11},
    {1'b1, 18'h20005, 16'hBEEF, 2'b10},
    {1'b0, 18'h20005, 16'h0000, 2'b10},
    {1'b0, 18'h20005, 16'h0000, 2'b01},
    {1'b1, 18'h0000A, 16'hFFFF, 2'b00},
    {1'b0, 18'h0000A, 16'h0000, 2'b11},
    {1'b1, 18'h3FFFF, 16'h5AA5, 2'b11},
    {1'b0, 18'h3FFFF, 16'h0000, 2'b11},
    {1'b0, 18'h00003, 16'h0000, 2'b10}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic wr, input logic [17:0] a,
                      input logic [15:0] d, input logic [1:0] m);
    int ceLow = 0, weLow = 0, oeLow = 0, oeCyc = 0, recCyc = 0;
    int rspCnt = 0, gapCyc = 0, laneBad = 0, addrBad = 0, dataBad = 0;
    int busy = 0;
    logic [15:0] got = '0;
    logic [15:0] expRd;
    expRd = {m[1] ? shadow[a[3:0]][15:8] : 8'h00,
             m[0] ? shadow[a[3:0]][7:0]  : 8'h00};
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 100 && !reqReady; i++) begin
      busy++;
      if (!memCeN) ceLow++;
      if (!memWeN) weLow++;
      if (!memOeN) oeLow++;
      if (memDqOe) oeCyc++;
      if (memDqOe && memWeN) recCyc++;
      if (rspValid) begin rspCnt++; got = rspData; end
      if (memCeN && memOeN && memWeN && memUbN && memLbN && !memDqOe) gapCyc++;
      if (!memCeN && ((memLbN != !m[0]) || (memUbN != !m[1]))) laneBad++;
      if ((!memCeN || memDqOe) && memAddr != a) addrBad++;
      if (memDqOe && memDqOut != d) dataBad++;
      @(negedge clk);
    end
    if (wr) begin
      chk(busy == WP_EXP + RC_EXP, "R2", "write busy cycles", busy, WP_EXP + RC_EXP);
      chk(weLow == WP_EXP, "R5", "write strobe cycles", weLow, WP_EXP);
      chk(ceLow == WP_EXP && oeLow == 0, "R5", "CE low / OE low", ceLow*256+oeLow, WP_EXP*256);
      chk(laneBad == 0, "R5", "lane enables vs mask", laneBad, 0);
      chk(recCyc == RC_EXP, "R6", "recovery cycles", recCyc, RC_EXP);
      chk(dataBad == 0 && addrBad == 0, "R6", "held addr/data", dataBad*256+addrBad, 0);
      chk(oeCyc == WP_EXP + RC_EXP, "R7", "bus drive cycles", oeCyc, WP_EXP + RC_EXP);
      if (m[0]) shadow[a[3:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[3:0]][15:8] = d[15:8];
    end else begin
      chk(busy == RD_EXP + 1, "R2", "read busy cycles", busy, RD_EXP + 1);
      chk(ceLow == RD_EXP && oeLow == RD_EXP && weLow == 0, "R3", "read strobe cycles",
          ceLow*256+oeLow, RD_EXP*257);
      chk(laneBad == 0 && addrBad == 0, "R3", "lanes/address", laneBad*256+addrBad, 0);
      chk(rspCnt == 1, "R4", "rspValid pulses", rspCnt, 1);
      chk(got == expRd, "R4", "read data", got, expRd);
      chk(gapCyc >= 1, "R8", "gap cycles", gapCyc, 1);
      chk(oeCyc == 0, "R7", "bus driven during read", oeCyc, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected <= 20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin bmem[i] = '0; shadow[i] = '0; end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; reqMask = '0;
    repeat (3) @(negedge clk);
    chk(memCeN && memWeN && memOeN && memUbN && memLbN, "R1", "strobes in reset",
        {memCeN, memWeN, memOeN, memUbN, memLbN}, 5'h1F);
    chk(!memDqOe && !rspValid && !reqReady, "R1", "outputs in reset",
        {memDqOe, rspValid, reqReady}, 0);

    // Startup window, with a write request offered early that must be ignored
    rstN = 1'b1;
    reqValid = 1'b1; reqWrite = 1'b1; reqMask = 2'b11; reqWdata = 16'hFFFF;
    begin
      int bad = 0;
      for (int k = 1; k < START; k++) begin
        @(negedge clk);
        if (k == 10) reqValid = 1'b0;
        if (reqReady || !memCeN || !memWeN || memDqOe) bad++;
      end
      chk(bad == 0, "R1", "activity during startup", bad, 0);
    end
    @(negedge clk);
    chk(reqReady && memCeN, "R1", "ready after startup", reqReady, 1);
    chk(bmem[0] == 16'h0000, "R2", "no write taken during startup", bmem[0], 0);

    for (int v = 0; v < NVEC; v++)
      doOp(VEC[v][36], VEC[v][35:18], VEC[v][17:2], VEC[v][1:0]);

    chk(bmem[10] == 16'h0000, "R9", "masked-off write left word", bmem[10], 0);

    // Reset in the middle of a write pulse
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00007;
    reqWdata = 16'hC3C3; reqMask = 2'b11;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk(!memWeN, "R5", "write strobe active before reset", memWeN, 0);
    rstN = 1'b0;
    #1;
    chk(memWeN && memCeN && !memDqOe && !reqReady, "R1", "async reset ends write",
        {memWeN, memCeN, memDqOe, reqReady}, 4'hC);
    @(negedge clk);
    rstN = 1'b1;
    repeat (START) @(negedge clk);
    doOp(1'b0, 18'h00003, 16'h0000, 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule